// File: doc/BRIEF.md
# Shared I/O Pin Driver Bank

This block drives a bank of I/O pads, one bit per pin, on behalf of two possible owners: a set of general-purpose registers written by a processor, and one dedicated internal function per pin, such as a step generator or a serial port. The block tests each pin's function-enable input. When it is high, a multiplexer hands that pin's output data and output enable to the internal function. When it is low, the registers own the pin. The two sources are selected, never ORed together. Which function is wired to which pin is fixed when the design is built.

Each pin has four register bits: output data, output enable, open-collector select and polarity inversion. Together they give these pin modes:
- off (high impedance)
- totem-pole output
- tri-state output controlled by its own enable
- open-collector output, where a logic 0 pulls the pad low and a logic 1 releases it

The input level of every pad passes through a two-stage synchroniser and can always be read back, even while an internal function drives the pin. This lets the outputs of the dedicated functions be observed for diagnostics. The same synchronised level, after inversion, is passed to the internal function as its input.

The register port is plain. A single-cycle write strobe carries an address and data. The read data is a combinational function of the read address.

Top module: `gpio_pin_bank`

## Requirements
- R1: While reset is asserted, the output data, output enable, open-collector and inversion registers read 0, and every pad_oe bit is 0.
- R2: A write with wr_en high takes effect at the rising clock edge that samples it. After that edge the register reads back the written value: address 0 is output data, address 1 is output enable, address 2 is open-collector select, address 3 is inversion.
- R3: Address 4 reads the input value. For each pin this is the pad level after two clock edges of synchronisation, XORed with that pin's inversion bit. fn_in carries the same value.
- R4: With the open-collector bit at 0, pad_out equals the selected data XOR the inversion bit, and pad_oe equals the selected output enable.
- R5: With the open-collector bit at 1, pad_out is 0. pad_oe is 1 only when the selected enable is 1 and the selected data XOR inversion is 0.
- R6: When fn_en is 1 for a pin, fn_out and fn_oe replace that pin's output data and output enable register bits. When fn_en is 0, the registers are used.
- R7: The input read at address 4 stays live while a function owns the pin, so a function's driven level can be observed.
- R8: Writes to address 4 and to addresses 5 to 7 change no register. Reads from addresses 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 24 | Write data, one bit per pin |
| rd_addr | input | 3 | Read address |
| rd_data | output | 24 | Read data |
| fn_en | input | 24 | Per-pin internal function ownership |
| fn_out | input | 24 | Internal function output data |
| fn_oe | input | 24 | Internal function output enable |
| fn_in | output | 24 | Synchronised, inverted pad level to internal function |
| pad_in | input | 24 | Pad input level |
| pad_out | output | 24 | Pad output data |
| pad_oe | output | 24 | Pad output enable |

## Verification
The pad outputs are combinational from the registers and the function inputs. A corrupted register bit or a wrong multiplexer select therefore shows at pad_out or pad_oe right after the clock edge that wrote it. A stale or mis-timed synchroniser stage shows at address 4 and at fn_in exactly two edges after a pad changes. A wrong inversion in one direction appears as a mismatch between the pad level that was driven and the level read back.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_DOUT = 3'd0;
  localparam logic [ADDR_W-1:0] A_OE   = 3'd1;
  localparam logic [ADDR_W-1:0] A_OC   = 3'd2;
  localparam logic [ADDR_W-1:0] A_INV  = 3'd3;
  localparam logic [ADDR_W-1:0] A_IN   = 3'd4;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 24,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int WIDTH = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [WIDTH-1:0]  in_val,
  output logic [WIDTH-1:0]  rd_data,
  output logic [WIDTH-1:0]  dout_q,
  output logic [WIDTH-1:0]  oe_q,
  output logic [WIDTH-1:0]  oc_q,
  output logic [WIDTH-1:0]  inv_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      oe_q   <= '0;
      oc_q   <= '0;
      inv_q  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_DOUT:  dout_q <= wr_data;
        A_OE:    oe_q   <= wr_data;
        A_OC:    oc_q   <= wr_data;
        A_INV:   inv_q  <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_addr)
      A_DOUT:  rd_data = dout_q;
      A_OE:    rd_data = oe_q;
      A_OC:    rd_data = oc_q;
      A_INV:   rd_data = inv_q;
      A_IN:    rd_data = in_val;
      default: rd_data = '0;
    endcase
  end

  AST_RESET_HIZ: assert property (@(posedge clk) !rst_n |-> (oe_q == '0)); // R1
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_OE) |=> (oe_q == $past(wr_data))); // R2
  AST_IGNORED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= A_IN) |=> $stable(dout_q) && $stable(oe_q)); // R8
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic reg_d,
  input  logic reg_oe,
  input  logic oc,
  input  logic inv,
  input  logic fn_en,
  input  logic fn_d,
  input  logic fn_oe,
  output logic pad_out,
  output logic pad_oe
);
  logic sel_d, sel_oe, drv_d;

  // True selection between owners, not an OR of both
  assign sel_d  = fn_en ? fn_d  : reg_d;
  assign sel_oe = fn_en ? fn_oe : reg_oe;
  assign drv_d  = sel_d ^ inv;

  always_comb begin
    if (oc) begin
      pad_out = 1'b0;
      pad_oe  = sel_oe & ~drv_d;
    end else begin
      pad_out = drv_d;
      pad_oe  = sel_oe;
    end
  end

  AST_OC_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (oc && pad_oe) |-> !pad_out); // R5
  AST_FN_OWNS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_en && !fn_oe) |-> !pad_oe); // R6
endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank
  import gpio_pkg::*;
#(
  parameter int NPINS = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NPINS-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [NPINS-1:0]  rd_data,
  input  logic [NPINS-1:0]  fn_en,
  input  logic [NPINS-1:0]  fn_out,
  input  logic [NPINS-1:0]  fn_oe,
  output logic [NPINS-1:0]  fn_in,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe
);
  logic [NPINS-1:0] dout_q, oe_q, oc_q, inv_q, pad_sync, in_val;

  gpio_in_sync #(.WIDTH(NPINS), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_sync)
  );

  assign in_val = pad_sync ^ inv_q;
  assign fn_in  = in_val;

  gpio_regs #(.WIDTH(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .in_val(in_val),
    .rd_data(rd_data), .dout_q(dout_q), .oe_q(oe_q), .oc_q(oc_q),
    .inv_q(inv_q)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    gpio_pin_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .reg_d(dout_q[p]), .reg_oe(oe_q[p]), .oc(oc_q[p]), .inv(inv_q[p]),
      .fn_en(fn_en[p]), .fn_d(fn_out[p]), .fn_oe(fn_oe[p]),
      .pad_out(pad_out[p]), .pad_oe(pad_oe[p])
    );
  end
endmodule

// File: tb/gpio_pin_bank_bench.sv
module gpio_pin_bank_bench;
  localparam int N = 24;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [N-1:0] wr_data = 0, rd_data, fn_en = 0, fn_out = 0, fn_oe = 0, fn_in;
  logic [N-1:0] pad_in = 0, pad_out, pad_oe;
  logic [N-1:0] m_d = 0, m_oe = 0, m_oc = 0, m_inv = 0;
  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_pin_bank #(.NPINS(N)) u_gpio_pin_bank (.*);

  function automatic logic [N-1:0] exp_out();
    logic [N-1:0] d = (fn_en & fn_out) | (~fn_en & m_d);
    return ~m_oc & (d ^ m_inv);
  endfunction
  function automatic logic [N-1:0] exp_oe();
    logic [N-1:0] d = (fn_en & fn_out) | (~fn_en & m_d);
    logic [N-1:0] e = (fn_en & fn_oe) | (~fn_en & m_oe);
    return (m_oc & e & ~(d ^ m_inv)) | (~m_oc & e);
  endfunction

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [N-1:0] v);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = v;
    @(negedge clk);
    wr_en = 0;
    case (a)
      3'd0: m_d = v;
      3'd1: m_oe = v;
      3'd2: m_oc = v;
      3'd3: m_inv = v;
      default: ;
    endcase
  endtask

  task automatic rd_chk(string req, logic [2:0] a, logic [N-1:0] exp);
    rd_addr = a; #1;
    chk(req, rd_data, exp);
  endtask

  task automatic pads_chk(string req);
    #1;
    chk(req, pad_out, exp_out());
    chk(req, pad_oe, exp_oe());
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    pad_in = 24'hFFFFFF;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) rd_chk("R1", 3'(a), '0);
    chk("R1 pad_oe", pad_oe, '0);
    rst_n = 1;
    // R2 write/readback
    wr(3'd0, 24'hA5A5A5); wr(3'd1, 24'h00FFFF);
    wr(3'd2, 24'h0F0F00); wr(3'd3, 24'h3C0003);
    rd_chk("R2", 3'd0, 24'hA5A5A5); rd_chk("R2", 3'd1, 24'h00FFFF);
    rd_chk("R2", 3'd2, 24'h0F0F00); rd_chk("R2", 3'd3, 24'h3C0003);
    // R4 totem, R5 open collector
    wr(3'd2, 24'h000000); pads_chk("R4");
    wr(3'd2, 24'hFFFFFF); pads_chk("R5");
    chk("R5 out low", pad_out, '0);
    // R3 two-edge synchroniser latency
    wr(3'd3, 24'h000000);
    @(negedge clk); pad_in = 24'h123456;
    rd_addr = 3'd4;
    @(negedge clk); #1;
    chk("R3 not yet", rd_data, 24'hFFFFFF);
    @(negedge clk); #1;
    chk("R3 after two", rd_data, 24'h123456);
    chk("R3 fn_in", fn_in, 24'h123456);
    wr(3'd3, 24'hFF0000);
    rd_chk("R3 inverted", 3'd4, 24'hED3456);
    // R8 ignored writes and unmapped reads
    wr(3'd4, 24'h000000); wr(3'd6, 24'h5A5A5A);
    rd_chk("R8 in live", 3'd4, 24'hED3456);
    rd_chk("R8 dout kept", 3'd0, 24'hA5A5A5);
    rd_chk("R8 oe kept", 3'd1, 24'h00FFFF);
    rd_chk("R8 unmapped", 3'd5, '0);
    rd_chk("R8 unmapped", 3'd7, '0);
    // R6 override, R7 live readback of function output
    wr(3'd2, 24'h000000); wr(3'd3, 24'h000000);
    @(negedge clk);
    fn_en = 24'h0000FF; fn_out = 24'h00005A; fn_oe = 24'h0000F0;
    pads_chk("R6");
    pad_in = pad_out;
    @(negedge clk); @(negedge clk);
    rd_chk("R7", 3'd4, pad_out);
    // Random mix
    for (int i = 0; i < 150; i++) begin
      wr(3'd0, N'($urandom)); wr(3'd1, N'($urandom));
      wr(3'd2, N'($urandom)); wr(3'd3, N'($urandom));
      fn_en = N'($urandom); fn_out = N'($urandom); fn_oe = N'($urandom);
      pad_in = N'($urandom);
      pads_chk(m_oc == '0 ? "R4" : "R5/R6");
      @(negedge clk); @(negedge clk);
      rd_chk("R3/R7", 3'd4, pad_in ^ m_inv);
      chk("R3 fn_in", fn_in, pad_in ^ m_inv);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule